// File: doc/BRIEF.md
# Pipelined 5x5 Matrix Multiplier

This block multiplies two 5x5 matrices of signed 8-bit elements and writes the 5x5 matrix of 16-bit results. The row and column loops are merged into a single sequence of 25 result indices. A new index is issued every clock, so one result is written per cycle once the pipeline has filled. Matrix A sits in a memory whose words each hold a complete row. Matrix B sits in a memory whose words each hold a complete column. One read from each memory therefore supplies all five operand pairs for a result, and the five products are formed side by side.

A run begins with a one-cycle start request. The block reports idle and ready while no run is active and pulses done when the last result has been written. Results leave through a write port that carries an address, data and an enable. The read ports behave as synchronous memories: data appears one cycle after its address.

Top module: `mat5_mac_pipe`

## Requirements
- R1: Each written result (i,j) equals the sum over k of A[i][k]*B[k][j]. Each product is a signed 8x8 product sign-extended to 16 bits, and the sum starts at zero and wraps modulo 2^16.
- R2: `aRowAddr` carries the row index i (0..4), and bits [8k+7:8k] of `aRowData` hold A[i][k]. `bColAddr` carries the column index j (0..4), and bits [8k+7:8k] of `bColData` hold B[k][j]. Read data is expected one cycle after the address.
- R3: Results are written in row-major order with `resAddr` = 5*i+j. The 25 writes fall in 25 consecutive cycles. The first write enable is visible in the cycle that follows the third clock edge after the accepting edge, which gives a depth of four cycles per result.
- R4: `doneOut` is high for exactly one cycle per run. It appears in the 29th cycle counted from the cycle that follows the accepting edge.
- R5: `idleOut` and `readyOut` are high exactly while no run is active. They fall after the edge that accepts start and rise in the same cycle as `doneOut`.
- R6: A start request made while a run is active is ignored. The run keeps its timing and still makes exactly 25 writes, and no second run follows.
- R7: A start request made in the cycle where `doneOut` is high is accepted, so a second run follows with no gap.
- R8: After reset, idle and ready are high and done and write enable are low.
- R9: Wrap case: when every element of A and B is -128, every result is 16384 (81920 mod 65536).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| startReq | input | 1 | Request to begin a run, taken when ready |
| doneOut | output | 1 | One-cycle pulse after the last write |
| idleOut | output | 1 | No run active |
| readyOut | output | 1 | A start would be accepted |
| aRowAddr | output | 3 | Row index into A memory |
| aRowData | input | 40 | Whole row of A, element k at bits [8k+7:8k] |
| bColAddr | output | 3 | Column index into B memory |
| bColData | input | 40 | Whole column of B, element k at bits [8k+7:8k] |
| resAddr | output | 5 | Result address 5*i+j |
| resData | output | 16 | Result value |
| resWrEn | output | 1 | Result write strobe |

## Verification
Two events can meet in one cycle. The done pulse of one run can coincide with the start that launches the next. The bench provokes this by raising start at the moment done is seen, then checks that idle drops at once and that the second run keeps the 29-cycle timing and produces the values for the freshly loaded B. Inside a run, the read for index n+3 is issued in the same cycle as the write for index n. The anti-diagonal test covers this overlap: its results are B with its rows reversed, so any slip between the read and write stages shows up as a wrong row.

// File: rtl/mat5_pkg.sv
package mat5_pkg;
  // Strobes from control to datapath, one per pipeline register bank
  typedef struct packed {
    logic capProd;   // operand words are on the read buses: latch products
    logic capSum;    // products are latched: latch their sum
  } dpStrobe_t;
endpackage

// File: rtl/mat5_ctrl.sv
module mat5_ctrl
  import mat5_pkg::*;
#(
  parameter int DIM = 5,
  parameter int IW  = $clog2(DIM),
  parameter int OW  = $clog2(DIM*DIM)
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          startReq,
  output logic [IW-1:0] rowIdx,
  output logic [IW-1:0] colIdx,
  output dpStrobe_t     strobe,
  output logic          wrEn,
  output logic [OW-1:0] wrAddr,
  output logic          doneOut,
  output logic          idleOut,
  output logic          readyOut
);
  localparam int LASTLIN = DIM*DIM - 1;
  localparam int LASTIX  = DIM - 1;

  logic          busy;
  logic          issueVld;
  logic [OW-1:0] linIdx;
  logic          vldRd, vldMul;
  logic [OW-1:0] linRd, linMul;
  logic          lastRd, lastMul, lastWr;
  logic          accept;
  logic          issueLast;

  assign accept    = startReq && !busy;
  assign issueLast = issueVld && (linIdx == OW'(LASTLIN));

  // Issue stage: walk the merged row/column loop, one index per cycle
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      issueVld <= 1'b0;
      rowIdx   <= '0;
      colIdx   <= '0;
      linIdx   <= '0;
    end else if (accept) begin
      issueVld <= 1'b1;
      rowIdx   <= '0;
      colIdx   <= '0;
      linIdx   <= '0;
    end else if (issueVld) begin
      if (issueLast) begin
        issueVld <= 1'b0;
      end else begin
        linIdx <= linIdx + 1'b1;
        if (colIdx == IW'(LASTIX)) begin
          colIdx <= '0;
          rowIdx <= rowIdx + 1'b1;
        end else begin
          colIdx <= colIdx + 1'b1;
        end
      end
    end
  end

  // Valid, address and last flags travel alongside the data
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      vldRd  <= 1'b0;
      vldMul <= 1'b0;
      wrEn   <= 1'b0;
      linRd  <= '0;
      linMul <= '0;
      wrAddr <= '0;
      lastRd <= 1'b0;
      lastMul <= 1'b0;
      lastWr <= 1'b0;
    end else begin
      vldRd   <= issueVld;
      linRd   <= linIdx;
      lastRd  <= issueLast;
      vldMul  <= vldRd;
      linMul  <= linRd;
      lastMul <= lastRd;
      wrEn    <= vldMul;
      wrAddr  <= linMul;
      lastWr  <= lastMul;
    end
  end

  // Run state and completion pulse
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      busy    <= 1'b0;
      doneOut <= 1'b0;
    end else begin
      doneOut <= wrEn && lastWr;
      if (accept)
        busy <= 1'b1;
      else if (wrEn && lastWr)
        busy <= 1'b0;
    end
  end

  assign strobe.capProd = vldRd;
  assign strobe.capSum  = vldMul;
  assign idleOut        = !busy;
  assign readyOut       = !busy;
endmodule

// File: rtl/mat5_dp.sv
module mat5_dp
  import mat5_pkg::*;
#(
  parameter int DIM = 5,
  parameter int EW  = 8,
  parameter int RW  = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpStrobe_t         strobe,
  input  logic [DIM*EW-1:0] aWord,
  input  logic [DIM*EW-1:0] bWord,
  output logic [RW-1:0]     sumOut
);
  logic [DIM-1:0][RW-1:0] mulExt;
  logic [DIM-1:0][RW-1:0] prodReg;
  logic [RW-1:0]          acc;

  // One signed multiplier per operand pair
  for (genvar k = 0; k < DIM; k++) begin : g_lane
    logic signed [EW-1:0]   aEl;
    logic signed [EW-1:0]   bEl;
    logic signed [2*EW-1:0] mulFull;
    assign aEl       = aWord[k*EW +: EW];
    assign bEl       = bWord[k*EW +: EW];
    assign mulFull   = aEl * bEl;
    assign mulExt[k] = RW'(mulFull);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)
      prodReg <= '0;
    else if (strobe.capProd)
      prodReg <= mulExt;
  end

  always_comb begin
    acc = '0;
    for (int k = 0; k < DIM; k++)
      acc = acc + prodReg[k];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)
      sumOut <= '0;
    else if (strobe.capSum)
      sumOut <= acc;
  end
endmodule

// File: rtl/mat5_mac_pipe.sv
module mat5_mac_pipe
  import mat5_pkg::*;
#(
  parameter int DIM = 5,
  parameter int EW  = 8,
  parameter int RW  = 16,
  localparam int IW = $clog2(DIM),
  localparam int OW = $clog2(DIM*DIM)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              startReq,
  output logic              doneOut,
  output logic              idleOut,
  output logic              readyOut,
  output logic [IW-1:0]     aRowAddr,
  input  logic [DIM*EW-1:0] aRowData,
  output logic [IW-1:0]     bColAddr,
  input  logic [DIM*EW-1:0] bColData,
  output logic [OW-1:0]     resAddr,
  output logic [RW-1:0]     resData,
  output logic              resWrEn
);
  dpStrobe_t strobe;

  mat5_ctrl #(.DIM(DIM), .IW(IW), .OW(OW)) ctrl_i (
    .clk      (clk),
    .rstN     (rstN),
    .startReq (startReq),
    .rowIdx   (aRowAddr),
    .colIdx   (bColAddr),
    .strobe   (strobe),
    .wrEn     (resWrEn),
    .wrAddr   (resAddr),
    .doneOut  (doneOut),
    .idleOut  (idleOut),
    .readyOut (readyOut)
  );

  mat5_dp #(.DIM(DIM), .EW(EW), .RW(RW)) dp_i (
    .clk    (clk),
    .rstN   (rstN),
    .strobe (strobe),
    .aWord  (aRowData),
    .bWord  (bColData),
    .sumOut (resData)
  );
endmodule

// File: rtl/mat5_mac_pipe_chk.sv
module mat5_mac_pipe_chk #(
  parameter int DIM = 5,
  parameter int IW  = $clog2(DIM),
  parameter int OW  = $clog2(DIM*DIM)
) (
  input logic          clk,
  input logic          rstN,
  input logic          startReq,
  input logic          doneOut,
  input logic          idleOut,
  input logic          readyOut,
  input logic [IW-1:0] aRowAddr,
  input logic [IW-1:0] bColAddr,
  input logic [OW-1:0] resAddr,
  input logic          resWrEn
);
  // R4
  done_one_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    doneOut |=> !doneOut);

  // R5
  idle_rise_with_done_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(idleOut) |-> doneOut);

  // R5
  done_leaves_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    doneOut |-> (idleOut && readyOut));

  // R6
  busy_start_ignored_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!idleOut && !doneOut && startReq) |=> !idleOut || doneOut);

  // R3
  wr_addr_step_chk: assert property (@(posedge clk) disable iff (!rstN)
    (resWrEn && resAddr != '0) |-> ($past(resWrEn) && resAddr == OW'($past(resAddr) + 1'b1)));

  // R3
  wr_in_run_chk: assert property (@(posedge clk) disable iff (!rstN)
    resWrEn |-> !idleOut);

  // R2
  rd_addr_range_chk: assert property (@(posedge clk) disable iff (!rstN)
    (aRowAddr < IW'(DIM)) && (bColAddr < IW'(DIM)));
endmodule

bind mat5_mac_pipe mat5_mac_pipe_chk #(.DIM(DIM)) chk_i (
  .clk      (clk),
  .rstN     (rstN),
  .startReq (startReq),
  .doneOut  (doneOut),
  .idleOut  (idleOut),
  .readyOut (readyOut),
  .aRowAddr (aRowAddr),
  .bColAddr (bColAddr),
  .resAddr  (resAddr),
  .resWrEn  (resWrEn)
);

// File: tb/mat5_mac_pipe_tb_top.sv
module mat5_mac_pipe_tb_top;
  localparam int DIM = 5;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        startReq = 1'b0;
  logic        doneOut, idleOut, readyOut, resWrEn;
  logic [2:0]  aRowAddr, bColAddr;
  logic [39:0] aRowData = '0, bColData = '0;
  logic [39:0] aPend = '0, bPend = '0;
  logic [4:0]  resAddr;
  logic [15:0] resData;

  int aM [DIM][DIM];
  int bM [DIM][DIM];
  logic [15:0] got [DIM*DIM];
  int wrCyc [DIM*DIM];
  int cyc = 0;
  int wrTotal = 0;
  int orderErr = 0;
  int checks = 0;
  int failures = 0;
  bit finished = 0;

  always #10 clk = ~clk;  // 20 ns period

  mat5_mac_pipe dut_i (
    .clk(clk), .rstN(rstN), .startReq(startReq), .doneOut(doneOut),
    .idleOut(idleOut), .readyOut(readyOut), .aRowAddr(aRowAddr),
    .aRowData(aRowData), .bColAddr(bColAddr), .bColData(bColData),
    .resAddr(resAddr), .resData(resData), .resWrEn(resWrEn)
  );

  function automatic logic [39:0] rowWord(logic [2:0] i);
    logic [39:0] w = '0;
    if (i < 3'(DIM))
      for (int k = 0; k < DIM; k++) w[k*8 +: 8] = aM[i][k][7:0];
    return w;
  endfunction

  function automatic logic [39:0] colWord(logic [2:0] j);
    logic [39:0] w = '0;
    if (j < 3'(DIM))
      for (int k = 0; k < DIM; k++) w[k*8 +: 8] = bM[k][j][7:0];
    return w;
  endfunction

  function automatic logic [15:0] expEl(int i, int j);
    int s = 0;
    for (int k = 0; k < DIM; k++) s += aM[i][k] * bM[k][j];
    return s[15:0];
  endfunction

  always @(posedge clk) cyc <= cyc + 1;

  // Synchronous-read memory model, evaluated away from the active edge
  always @(negedge clk) begin
    aPend    <= rowWord(aRowAddr);
    bPend    <= colWord(bColAddr);
    aRowData <= aPend;
    bColData <= bPend;
  end

  // Result memory and write-order monitor
  always @(negedge clk) begin
    if (rstN && resWrEn) begin
      if (int'(resAddr) != (wrTotal % 25)) orderErr++;
      got[resAddr]   = resData;
      wrCyc[resAddr] = cyc;
      wrTotal++;
    end
  end

  task automatic chk(string req, string what, longint act, longint exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic checkAll(string req);
    int bad = 0;
    for (int i = 0; i < DIM; i++)
      for (int j = 0; j < DIM; j++)
        if (got[i*DIM+j] !== expEl(i, j)) begin
          bad++;
          $display("FAIL %s element(%0d,%0d) actual=%0d expected=%0d",
                   req, i, j, got[i*DIM+j], expEl(i, j));
        end
    checks++;
    if (bad != 0) failures++;
  endtask

  // Start one run; optionally raise start again mid-run. Returns latency to done.
  task automatic runMat(bit midStart, output int lat, output int base);
    int n = 0;
    @(negedge clk); startReq = 1'b1;
    @(negedge clk); startReq = 1'b0;
    base = cyc;
    chk("R5", "idle after accept", idleOut, 0);
    while (!doneOut && n < 100) begin
      startReq = (midStart && n == 10);
      @(negedge clk);
      n++;
    end
    startReq = 1'b0;
    lat = n + 1;
  endtask

  task automatic testReset();
    chk("R8", "idle at reset", idleOut, 1);
    chk("R8", "ready at reset", readyOut, 1);
    chk("R8", "done at reset", doneOut, 0);
    chk("R8", "wren at reset", resWrEn, 0);
  endtask

  task automatic testAntiDiag();
    int lat, base, w0;
    for (int i = 0; i < DIM; i++)
      for (int j = 0; j < DIM; j++) begin
        aM[i][j] = (i + j == DIM - 1) ? 1 : 0;
        bM[i][j] = (j >= i) ? 1 : 0;
      end
    w0 = wrTotal;
    runMat(0, lat, base);
    chk("R4", "latency to done", lat, 29);
    chk("R3", "first write offset", wrCyc[0] - base, 3);
    chk("R3", "write burst span", wrCyc[24] - wrCyc[0], 24);
    chk("R3", "row-major order errors", orderErr, 0);
    chk("R3", "write count", wrTotal - w0, 25);
    checkAll("R1 R2 anti-diagonal");
    // product must be B with rows reversed
    chk("R1", "element(0,0) is B(4,0)", got[0], bM[4][0]);
    chk("R1", "element(4,4) is B(0,4)", got[24], bM[0][4]);
    chk("R5", "idle in done cycle", idleOut, 1);
    @(negedge clk);
    chk("R4", "done single pulse", doneOut, 0);
  endtask

  task automatic testWrap();
    int lat, base;
    for (int i = 0; i < DIM; i++)
      for (int j = 0; j < DIM; j++) begin
        aM[i][j] = -128;
        bM[i][j] = -128;
      end
    runMat(0, lat, base);
    chk("R9", "wrap element 0", got[0], 16384);
    chk("R9", "wrap element 24", got[24], 16384);
    checkAll("R9");
  endtask

  task automatic testMixed();
    int lat, base;
    int seed = 17;
    for (int i = 0; i < DIM; i++)
      for (int j = 0; j < DIM; j++) begin
        seed = (seed * 1103515245 + 12345) & 32'h7fffffff;
        aM[i][j] = ((seed >> 8) % 256) - 128;
        seed = (seed * 1103515245 + 12345) & 32'h7fffffff;
        bM[i][j] = ((seed >> 8) % 256) - 128;
      end
    aM[0][0] = 127; bM[0][0] = -128;
    runMat(0, lat, base);
    checkAll("R1 mixed signs");
  endtask

  task automatic testIgnoredStart();
    int lat, base, w0, extra = 0;
    w0 = wrTotal;
    runMat(1, lat, base);
    chk("R6", "latency with mid-run start", lat, 29);
    chk("R6", "write count with mid-run start", wrTotal - w0, 25);
    checkAll("R6");
    for (int c = 0; c < 6; c++) begin
      @(negedge clk);
      if (!idleOut || resWrEn || doneOut) extra++;
    end
    chk("R6", "no second run", extra, 0);
  endtask

  task automatic testBackToBack();
    int lat, base, n = 0;
    runMat(0, lat, base);
    // new B for second run, start raised in the done cycle
    for (int i = 0; i < DIM; i++)
      for (int j = 0; j < DIM; j++) bM[i][j] = i * 7 - j * 11;
    startReq = 1'b1;
    @(negedge clk);
    startReq = 1'b0;
    base = cyc;
    chk("R7", "second run accepted in done cycle", idleOut, 0);
    while (!doneOut && n < 100) begin
      @(negedge clk);
      n++;
    end
    chk("R7", "second run latency", n + 1, 29);
    chk("R7", "second run first write offset", wrCyc[0] - base, 3);
    checkAll("R7");
  endtask

  task automatic report();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    testReset();
    rstN = 1'b1;
    @(negedge clk);
    testAntiDiag();
    testWrap();
    testMixed();
    testIgnoredStart();
    testBackToBack();
    repeat (3) @(negedge clk);
    finished = 1;
    report();
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=timeout expected=completion");
      report();
      $finish;
    end
  end
endmodule